// File: doc/BRIEF.md
# Virtual Address Translation Checker

This block turns a 32-bit virtual address into a physical address, or into a fault, for one memory request per cycle. Each request carries the address, the kind of access (instruction fetch, load or store), the access size, the address-space ID and the processor status word. The block works out the privilege level from the status word. It maps the two directly mapped kernel windows without any table access. For every other address it forms a page number, drives it to an external TLB lookup port and reads back the matching entry in the same cycle.

For a mapped address, the block chooses the even or the odd half of the matching entry by looking at one address bit, whose position the entry gives. It then checks that half's valid and dirty bits and builds the physical address from that half's frame number. When a TLB fault occurs, it also fills in the fields that exception software needs: the faulting address, the ASID, the page-pair number with its two low bits, and the context page field. There is one registered result per request, marked by a one-cycle valid pulse. The TLB storage itself lies outside the block.

Top module: `va_xlate_check`

## Requirements
- R1: The privilege is kernel when status bit 28, 2 or 1 is set, or when status bits [4:3] are 00. Otherwise [4:3]=01 is supervisor, 10 is user and 11 is an invalid mode. Only kernel may use the cached kernel window.
- R2: An address in 0x80000000–0x9FFFFFFF maps to the physical address with bits [31:29] cleared. It raises fault code 1 (address error) if the privilege is not kernel or if the access is misaligned.
- R3: An address in 0xA0000000–0xBFFFFFFF maps to the physical address with bits [31:29] cleared. It has no privilege check and no alignment check.
- R4: For any request, `lk_vpn` equals vaddr[31:11] with its two low bits forced to 0 unless `small_pg` is 1. `lk_asid` equals `req_asid`.
- R5: On a hit, vaddr[`lk_shift`] selects the half: 0 picks frame/valid/dirty set 0 and 1 picks set 1.
- R6: A miss gives fault code 3 for a fetch and 5 for a load or store. A hit on a half that is not valid gives code 4 for a fetch and 6 for a load or store.
- R7: A store (kind 2) to a valid half whose dirty bit is clear gives fault code 7. Fetches (kind 0) and loads (kind 1) ignore the dirty bit.
- R8: On fault codes 3 to 7 the result carries the following: badvaddr set to the virtual address, the ASID, vpn2 set to page number >> 2, vpn2x set to the page number's bits [1:0], and a context field equal to vpn2. These fields are zero on faults 1 and 2 and on success, except that badvaddr also holds the address on faults 1 and 2.
- R9: On success in a mapped region, the physical address is computed in three steps. First, shift the selected frame number right by (`lk_shift` − 12). Second, shift that value left by `lk_shift`. Third, OR in vaddr & `lk_offmask`.
- R10: On success, the uncacheable flag is 1 exactly when vaddr & 0xA0000000 equals 0xA0000000.
- R11: A mapped access whose address is not a multiple of 2^`req_size` raises fault code 2 (alignment). This code wins over every TLB fault.
- R12: Results appear one cycle after the request. `rsp_valid` is high for exactly one cycle per request. The physical address is 0 on any fault. After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | 0 fetch, 1 load, 2 store, 3 treated as load |
| req_size | input | 2 | log2 of access bytes |
| req_asid | input | 8 | Address-space ID |
| req_status | input | 32 | Processor status word |
| small_pg | input | 1 | Keep the two low page-number bits |
| lk_vpn | output | 21 | Page number sent to the TLB |
| lk_asid | output | 8 | ASID sent to the TLB |
| lk_hit | input | 1 | TLB found a matching entry |
| lk_shift | input | 5 | Entry's half-select bit position (12..28) |
| lk_offmask | input | 32 | Entry's page offset mask |
| lk_pfn0 | input | 24 | Even half frame number |
| lk_pfn1 | input | 24 | Odd half frame number |
| lk_v0 | input | 1 | Even half valid |
| lk_v1 | input | 1 | Odd half valid |
| lk_d0 | input | 1 | Even half dirty (writable) |
| lk_d1 | input | 1 | Odd half dirty (writable) |
| rsp_valid | output | 1 | Result valid pulse |
| rsp_paddr | output | 32 | Physical address |
| rsp_fault | output | 3 | Fault code, 0 = none |
| rsp_uncached | output | 1 | Uncacheable request |
| rsp_badvaddr | output | 32 | Faulting virtual address |
| rsp_asid | output | 8 | ASID of TLB fault |
| rsp_vpn2 | output | 19 | Page-pair number of TLB fault |
| rsp_vpn2x | output | 2 | Low page-number bits of TLB fault |
| rsp_ctx_vpn2 | output | 19 | Context page field of TLB fault |

## Verification
The hardest cases to reach from the ports are those where several fault conditions are true at once. Examples are a misaligned store that also misses, and a store to a half that is valid but clean while the other half is dirty. In these cases the priority order decides which single code is reported. The stimulus drives the lookup-port inputs directly alongside each request, so each such overlap is built on purpose. It also puts the half-select bit at positions other than 12. The different frame numbers in the two halves then expose a wrong half choice as a wrong physical address.

// File: rtl/xc_pkg.sv
package xc_pkg;
  localparam int VA_W      = 32;
  localparam int PFN_W     = 24;
  localparam int ASID_W    = 8;
  localparam int SHIFT_W   = 5;
  localparam int PG_LSB    = 11;
  localparam int VPN_W     = VA_W - PG_LSB;
  localparam int VPN2_W    = VPN_W - 2;
  localparam int MIN_SHIFT = 12;

  typedef enum logic [1:0] {
    MODE_KERN = 2'd0,
    MODE_SUPV = 2'd1,
    MODE_USER = 2'd2,
    MODE_BAD  = 2'd3
  } mode_e;

  localparam logic [1:0] KIND_FETCH = 2'd0;
  localparam logic [1:0] KIND_STORE = 2'd2;

  localparam logic [2:0] FLT_NONE    = 3'd0;
  localparam logic [2:0] FLT_ADDR    = 3'd1;
  localparam logic [2:0] FLT_ALIGN   = 3'd2;
  localparam logic [2:0] FLT_IREFILL = 3'd3;
  localparam logic [2:0] FLT_IINVAL  = 3'd4;
  localparam logic [2:0] FLT_DREFILL = 3'd5;
  localparam logic [2:0] FLT_DINVAL  = 3'd6;
  localparam logic [2:0] FLT_MOD     = 3'd7;

  localparam logic [VA_W-1:0] UNC_PATTERN = 32'hA000_0000;
endpackage

// File: rtl/xc_mode_dec.sv
module xc_mode_dec
  import xc_pkg::*;
(
  input  logic [31:0] status,
  output mode_e       mode,
  output logic        is_kernel
);
  always_comb begin
    if (status[28] || status[2] || status[1] || (status[4:3] == 2'b00)) begin
      mode = MODE_KERN;
    end else begin
      case (status[4:3])
        2'b01:   mode = MODE_SUPV;
        2'b10:   mode = MODE_USER;
        default: mode = MODE_BAD;
      endcase
    end
    is_kernel = (mode == MODE_KERN);
  end
endmodule

// File: rtl/xc_seg_check.sv
module xc_seg_check
  import xc_pkg::*;
(
  input  logic [VA_W-1:0] vaddr,
  input  logic [1:0]      size_log2,
  input  logic            is_kernel,
  output logic            in_kcached,
  output logic            in_kuncached,
  output logic            misaligned,
  output logic            kcached_err,
  output logic [VA_W-1:0] direct_pa
);
  always_comb begin
    in_kcached   = (vaddr[VA_W-1:VA_W-3] == 3'b100);
    in_kuncached = (vaddr[VA_W-1:VA_W-3] == 3'b101);
    case (size_log2)
      2'd0:    misaligned = 1'b0;
      2'd1:    misaligned = vaddr[0];
      2'd2:    misaligned = |vaddr[1:0];
      default: misaligned = |vaddr[2:0];
    endcase
    kcached_err = in_kcached && (!is_kernel || misaligned);
    direct_pa   = {3'b000, vaddr[VA_W-4:0]};
  end
endmodule

// File: rtl/xc_page_compose.sv
module xc_page_compose
  import xc_pkg::*;
(
  input  logic [VA_W-1:0]    vaddr,
  input  logic               small_pg,
  input  logic [SHIFT_W-1:0] shift,
  input  logic [VA_W-1:0]    offmask,
  input  logic [PFN_W-1:0]   pfn0,
  input  logic [PFN_W-1:0]   pfn1,
  input  logic               v0,
  input  logic               v1,
  input  logic               d0,
  input  logic               d1,
  output logic [VPN_W-1:0]   vpn,
  output logic               half_valid,
  output logic               half_dirty,
  output logic [VA_W-1:0]    mapped_pa
);
  logic               odd;
  logic [PFN_W-1:0]   pfn_sel;
  logic [VA_W-1:0]    pfn_ext;
  logic [SHIFT_W-1:0] rsh;

  always_comb begin
    vpn = vaddr[VA_W-1:PG_LSB];
    if (!small_pg) vpn[1:0] = 2'b00;
    odd        = vaddr[shift];
    pfn_sel    = odd ? pfn1 : pfn0;
    half_valid = odd ? v1 : v0;
    half_dirty = odd ? d1 : d0;
    rsh        = shift - SHIFT_W'(MIN_SHIFT);
    pfn_ext    = {{(VA_W-PFN_W){1'b0}}, pfn_sel};
    mapped_pa  = ((pfn_ext >> rsh) << shift) | (vaddr & offmask);
  end
endmodule

// File: rtl/va_xlate_check.sv
module va_xlate_check
  import xc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [31:0]          req_vaddr,
  input  logic [1:0]           req_kind,
  input  logic [1:0]           req_size,
  input  logic [7:0]           req_asid,
  input  logic [31:0]          req_status,
  input  logic                 small_pg,
  output logic [20:0]          lk_vpn,
  output logic [7:0]           lk_asid,
  input  logic                 lk_hit,
  input  logic [4:0]           lk_shift,
  input  logic [31:0]          lk_offmask,
  input  logic [23:0]          lk_pfn0,
  input  logic [23:0]          lk_pfn1,
  input  logic                 lk_v0,
  input  logic                 lk_v1,
  input  logic                 lk_d0,
  input  logic                 lk_d1,
  output logic                 rsp_valid,
  output logic [31:0]          rsp_paddr,
  output logic [2:0]           rsp_fault,
  output logic                 rsp_uncached,
  output logic [31:0]          rsp_badvaddr,
  output logic [7:0]           rsp_asid,
  output logic [18:0]          rsp_vpn2,
  output logic [1:0]           rsp_vpn2x,
  output logic [18:0]          rsp_ctx_vpn2
);
  mode_e           mode;
  logic            is_kernel;
  logic            in_k0, in_k1, misaligned, k0_err;
  logic [VA_W-1:0] direct_pa, mapped_pa;
  logic [VPN_W-1:0] vpn;
  logic            half_valid, half_dirty;

  xc_mode_dec u_mode (
    .status    (req_status),
    .mode      (mode),
    .is_kernel (is_kernel)
  );

  xc_seg_check u_seg (
    .vaddr        (req_vaddr),
    .size_log2    (req_size),
    .is_kernel    (is_kernel),
    .in_kcached   (in_k0),
    .in_kuncached (in_k1),
    .misaligned   (misaligned),
    .kcached_err  (k0_err),
    .direct_pa    (direct_pa)
  );

  xc_page_compose u_page (
    .vaddr      (req_vaddr),
    .small_pg   (small_pg),
    .shift      (lk_shift),
    .offmask    (lk_offmask),
    .pfn0       (lk_pfn0),
    .pfn1       (lk_pfn1),
    .v0         (lk_v0),
    .v1         (lk_v1),
    .d0         (lk_d0),
    .d1         (lk_d1),
    .vpn        (vpn),
    .half_valid (half_valid),
    .half_dirty (half_dirty),
    .mapped_pa  (mapped_pa)
  );

  assign lk_vpn  = vpn;
  assign lk_asid = req_asid;

  logic              is_fetch;
  logic              tlb_flt;
  logic [2:0]        n_fault;
  logic [VA_W-1:0]   n_paddr, n_bad;
  logic              n_unc;

  always_comb begin
    is_fetch = (req_kind == KIND_FETCH);
    tlb_flt  = 1'b0;
    n_fault  = FLT_NONE;
    n_paddr  = '0;
    n_bad    = '0;
    n_unc    = 1'b0;
    if (in_k0) begin
      if (k0_err) n_fault = FLT_ADDR;
      else        n_paddr = direct_pa;
    end else if (in_k1) begin
      n_paddr = direct_pa;
    end else if (misaligned) begin
      n_fault = FLT_ALIGN;
    end else if (!lk_hit) begin
      tlb_flt = 1'b1;
      n_fault = is_fetch ? FLT_IREFILL : FLT_DREFILL;
    end else if (!half_valid) begin
      tlb_flt = 1'b1;
      n_fault = is_fetch ? FLT_IINVAL : FLT_DINVAL;
    end else if ((req_kind == KIND_STORE) && !half_dirty) begin
      tlb_flt = 1'b1;
      n_fault = FLT_MOD;
    end else begin
      n_paddr = mapped_pa;
    end
    if (n_fault != FLT_NONE) n_bad = req_vaddr;
    else n_unc = ((req_vaddr & UNC_PATTERN) == UNC_PATTERN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_paddr    <= '0;
      rsp_fault    <= FLT_NONE;
      rsp_uncached <= 1'b0;
      rsp_badvaddr <= '0;
      rsp_asid     <= '0;
      rsp_vpn2     <= '0;
      rsp_vpn2x    <= '0;
      rsp_ctx_vpn2 <= '0;
    end else if (req_valid) begin
      rsp_paddr    <= n_paddr;
      rsp_fault    <= n_fault;
      rsp_uncached <= n_unc;
      rsp_badvaddr <= n_bad;
      rsp_asid     <= tlb_flt ? req_asid : '0;
      rsp_vpn2     <= tlb_flt ? vpn[VPN_W-1:2] : '0;
      rsp_vpn2x    <= tlb_flt ? vpn[1:0] : '0;
      rsp_ctx_vpn2 <= tlb_flt ? vpn[VPN_W-1:2] : '0;
    end
  end
endmodule

// File: rtl/va_xlate_check_chk.sv
module va_xlate_check_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [31:0] req_vaddr,
  input logic [1:0]  req_kind,
  input logic        small_pg,
  input logic [20:0] lk_vpn,
  input logic        rsp_valid,
  input logic [31:0] rsp_paddr,
  input logic [2:0]  rsp_fault,
  input logic [31:0] rsp_badvaddr,
  input logic [18:0] rsp_vpn2
);
  assert_valid_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_valid_needs_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  assert_fault_zero_pa_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 3'd0) |-> rsp_paddr == 32'd0);
  assert_kuncached_direct_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_vaddr[31:29] == 3'b101) |=>
      (rsp_fault == 3'd0 && rsp_paddr == {3'b000, $past(req_vaddr[28:0])}));
  assert_vpn_low_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !small_pg |-> lk_vpn[1:0] == 2'b00);
  assert_mod_only_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind != 2'd2) |=> rsp_fault != 3'd7);
  assert_vpn2_matches_bad_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault >= 3'd3) |-> rsp_vpn2 == rsp_badvaddr[31:13]);
endmodule

bind va_xlate_check va_xlate_check_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_vaddr    (req_vaddr),
  .req_kind     (req_kind),
  .small_pg     (small_pg),
  .lk_vpn       (lk_vpn),
  .rsp_valid    (rsp_valid),
  .rsp_paddr    (rsp_paddr),
  .rsp_fault    (rsp_fault),
  .rsp_badvaddr (rsp_badvaddr),
  .rsp_vpn2     (rsp_vpn2)
);

// File: tb/sim_va_xlate_check.sv
module sim_va_xlate_check;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [31:0] va;
    logic [1:0]  kind;
    logic [1:0]  size;
    logic [7:0]  asid;
    logic [31:0] st;
    logic        sp;
    logic        hit;
    logic [4:0]  sh;
    logic [31:0] om;
    logic [23:0] p0, p1;
    logic        v0, v1, d0, d1;
  } stim_t;

  typedef struct {
    logic [31:0] pa;
    logic [2:0]  flt;
    logic        unc;
    logic [31:0] bad;
    logic [7:0]  asid;
    logic [18:0] vpn2;
    logic [1:0]  vpn2x;
    logic [18:0] ctx;
    string       tag;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [31:0] req_vaddr = '0, req_status = '0, lk_offmask = '0;
  logic [1:0]  req_kind = '0, req_size = '0;
  logic [7:0]  req_asid = '0;
  logic        small_pg = 1'b0, lk_hit = 1'b0;
  logic [4:0]  lk_shift = 5'd12;
  logic [23:0] lk_pfn0 = '0, lk_pfn1 = '0;
  logic        lk_v0 = 1'b0, lk_v1 = 1'b0, lk_d0 = 1'b0, lk_d1 = 1'b0;
  logic [20:0] lk_vpn;
  logic [7:0]  lk_asid;
  logic        rsp_valid, rsp_uncached;
  logic [31:0] rsp_paddr, rsp_badvaddr;
  logic [2:0]  rsp_fault;
  logic [7:0]  rsp_asid;
  logic [18:0] rsp_vpn2, rsp_ctx_vpn2;
  logic [1:0]  rsp_vpn2x;

  int checks = 0, fails = 0;
  bit done = 0;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  va_xlate_check u0 (.*);

  function automatic exp_t model(stim_t s, string tag);
    exp_t e;
    logic mis, kern, odd, v, d;
    logic [20:0] vpn;
    logic [31:0] frame;
    e = '{pa: 0, flt: 0, unc: 0, bad: 0, asid: 0, vpn2: 0, vpn2x: 0, ctx: 0, tag: tag};
    mis  = (s.va & ((32'd1 << s.size) - 1)) != 0;
    kern = s.st[28] | s.st[2] | s.st[1] | (s.st[4:3] == 2'b00);
    vpn  = s.va[31:11];
    if (!s.sp) vpn[1:0] = 2'b00;
    if (s.va[31:29] == 3'b100) begin
      if (!kern || mis) e.flt = 3'd1; else e.pa = s.va & 32'h1FFF_FFFF;
    end else if (s.va[31:29] == 3'b101) begin
      e.pa = s.va & 32'h1FFF_FFFF;
    end else if (mis) begin
      e.flt = 3'd2;
    end else begin
      odd = s.va[s.sh];
      v = odd ? s.v1 : s.v0;
      d = odd ? s.d1 : s.d0;
      if (!s.hit) e.flt = (s.kind == 2'd0) ? 3'd3 : 3'd5;
      else if (!v) e.flt = (s.kind == 2'd0) ? 3'd4 : 3'd6;
      else if (s.kind == 2'd2 && !d) e.flt = 3'd7;
      else begin
        frame = {8'd0, (odd ? s.p1 : s.p0)};
        frame = frame >> (s.sh - 5'd12);
        e.pa  = (frame << s.sh) | (s.va & s.om);
      end
      if (e.flt >= 3'd3) begin
        e.asid = s.asid; e.vpn2 = vpn[20:2]; e.vpn2x = vpn[1:0]; e.ctx = vpn[20:2];
      end
    end
    if (e.flt != 0) e.bad = s.va;
    else e.unc = (s.va & 32'hA000_0000) == 32'hA000_0000;
    return e;
  endfunction

  task automatic send(stim_t s, string tag);
    logic [20:0] ev;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = s.va; req_kind = s.kind; req_size = s.size;
    req_asid = s.asid; req_status = s.st; small_pg = s.sp; lk_hit = s.hit;
    lk_shift = s.sh; lk_offmask = s.om; lk_pfn0 = s.p0; lk_pfn1 = s.p1;
    lk_v0 = s.v0; lk_v1 = s.v1; lk_d0 = s.d0; lk_d1 = s.d1;
    exp_q.push_back(model(s, tag));
    #1;
    ev = s.va[31:11];
    if (!s.sp) ev[1:0] = 2'b00;
    checks++;
    if (lk_vpn !== ev || lk_asid !== s.asid) begin
      fails++;
      $display("FAIL R4 %s: lk_vpn=%h lk_asid=%h expected %h %h", tag, lk_vpn, lk_asid, ev, s.asid);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R12: rsp_valid with nothing expected, actual 1 expected 0");
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (rsp_paddr !== e.pa || rsp_fault !== e.flt || rsp_uncached !== e.unc ||
            rsp_badvaddr !== e.bad || rsp_asid !== e.asid || rsp_vpn2 !== e.vpn2 ||
            rsp_vpn2x !== e.vpn2x || rsp_ctx_vpn2 !== e.ctx) begin
          fails++;
          $display("FAIL %s: pa=%h flt=%0d unc=%b bad=%h asid=%h vpn2=%h x=%h ctx=%h expected pa=%h flt=%0d unc=%b bad=%h asid=%h vpn2=%h x=%h ctx=%h",
            e.tag, rsp_paddr, rsp_fault, rsp_uncached, rsp_badvaddr, rsp_asid, rsp_vpn2,
            rsp_vpn2x, rsp_ctx_vpn2, e.pa, e.flt, e.unc, e.bad, e.asid, e.vpn2, e.vpn2x, e.ctx);
        end
      end
    end
  end

  function automatic stim_t base(logic [31:0] va, logic [1:0] kind, logic [31:0] st);
    stim_t s;
    s = '{va: va, kind: kind, size: 2'd2, asid: 8'h5A, st: st, sp: 1'b0, hit: 1'b1,
          sh: 5'd12, om: 32'h0000_0FFF, p0: 24'h0123, p1: 24'h0456,
          v0: 1'b1, v1: 1'b1, d0: 1'b1, d1: 1'b1};
    return s;
  endfunction

  initial begin
    #(CLK_PERIOD*100000);
    fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    if (!done) $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    stim_t s;
    #(CLK_PERIOD*3 + 2);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (rsp_valid !== 0 || rsp_paddr !== 0 || rsp_fault !== 0 || rsp_badvaddr !== 0) begin
      fails++;
      $display("FAIL R12 reset: valid=%b pa=%h flt=%0d expected 0 0 0", rsp_valid, rsp_paddr, rsp_fault);
    end
    // R1 and R2: privilege decode seen through the cached kernel window
    send(base(32'h8000_1234, 2'd1, 32'h0000_0000), "R1 R2 kernel 00");
    send(base(32'h8000_1234, 2'd1, 32'h0000_0010), "R1 R2 user");
    send(base(32'h8000_1234, 2'd1, 32'h0000_0008), "R1 R2 supervisor");
    send(base(32'h9FFF_FFFC, 2'd0, 32'h0000_0018), "R1 R2 bad mode");
    send(base(32'h8400_0000, 2'd1, 32'h1000_0010), "R1 bit28 kernel");
    send(base(32'h8400_0000, 2'd1, 32'h0000_0012), "R1 bit1 kernel");
    send(base(32'h8400_0000, 2'd2, 32'h0000_0014), "R1 bit2 kernel");
    idle();
    s = base(32'h8000_0002, 2'd1, 32'h0); send(s, "R2 misaligned kernel");
    // R3: uncached kernel window ignores privilege and alignment
    s = base(32'hA123_4567, 2'd2, 32'h0000_0010); send(s, "R3 R10 user misaligned");
    // R6 and R8: misses, with and without small pages
    s = base(32'h0040_3800, 2'd0, 32'h10); s.hit = 0; send(s, "R6 R8 fetch refill");
    s = base(32'h7FFF_F804, 2'd1, 32'h10); s.hit = 0; s.sp = 1; s.asid = 8'hC3; send(s, "R4 R6 R8 load refill small");
    idle();
    // R5 and R9: half selection
    s = base(32'h1000_0ABC, 2'd1, 32'h10); send(s, "R5 R9 even half");
    s = base(32'h1000_1ABC, 2'd1, 32'h10); send(s, "R5 R9 odd half");
    s = base(32'h2000_4010, 2'd0, 32'h10); s.sh = 5'd14; s.om = 32'h3FFF;
    s.p0 = 24'h00_0A0; s.p1 = 24'h00_0B4; send(s, "R5 R9 shift14 odd");
    s.va = 32'h2000_B010; send(s, "R5 R9 shift14 even");
    // R6: invalid halves
    s = base(32'h0300_1000, 2'd0, 32'h10); s.v1 = 0; send(s, "R6 R8 fetch invalid");
    s = base(32'h0300_0000, 2'd2, 32'h10); s.v0 = 0; send(s, "R6 R8 store invalid");
    // R7: dirty handling
    s = base(32'h0500_1008, 2'd2, 32'h10); s.d1 = 0; send(s, "R7 store clean");
    s.kind = 2'd1; send(s, "R7 load clean ok");
    s.kind = 2'd2; s.va = 32'h0500_0008; send(s, "R7 store other half dirty");
    // R11: misalignment beats TLB faults
    s = base(32'h0600_0002, 2'd2, 32'h10); s.hit = 0; send(s, "R11 misaligned miss");
    s = base(32'h0600_0001, 2'd1, 32'h10); s.size = 2'd1; s.v0 = 0; send(s, "R11 misaligned invalid");
    s = base(32'h0600_0006, 2'd1, 32'h10); s.size = 2'd1; send(s, "R11 size2 aligned");
    // R10: mapped high region flagged uncacheable
    s = base(32'hE000_2100, 2'd1, 32'h10); send(s, "R10 mapped uncached");
    s = base(32'hC000_2100, 2'd1, 32'h10); send(s, "R10 mapped cached");
    idle();
    idle();
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R12: %0d results missing, expected 0", exp_q.size());
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule